// File: doc/BRIEF.md
# I2C Register Transaction Master

This block is a single-master I2C controller that runs one complete register access per request. The host places a 7-bit device address, an 8-bit register index and, for a write, an 8-bit value on its inputs and pulses `start`. The block then produces the whole bus sequence on open-drain SCL and SDA lines. For a read, it returns the fetched byte. It finishes with a one-cycle `done` pulse and an error code.

If any acknowledge slot reads high, the block completes the current attempt down to its STOP and then runs the whole transaction again from START. The number of automatic repeats is a parameter. The error code reported is the one from the final attempt.

All bus phase lengths are counted in ticks of a clock-enable. The `prescale` input sets the tick spacing. The block assumes a single master on the bus, no clock stretching by the slave, 7-bit addressing and single-byte data.

Top module: `i2c_regm`

## Requirements
- R1: A write runs START, address byte with its last bit 0, register index byte, data byte, STOP, with an acknowledge slot after each byte. Bytes go out most significant bit first, and the addressed slave register holds the value afterwards.
- R2: The write error code is a mask. Bit 0 is set when the address slot was not acknowledged, bit 1 when the register index slot was not acknowledged, and bit 2 when the data slot was not acknowledged. A slot counts as acknowledged only if SDA reads low while SCL is high.
- R3: A transaction with any unacknowledged slot is repeated from START, up to RETRIES (default 3) extra times. Repeating stops at the first clean attempt, which reports err = 0. After the final attempt fails, the last error code is reported.
- R4: A read runs START, address with last bit 0, register index, a gap of one low period, repeated START, address with last bit 1, one received byte, STOP. Any unacknowledged slot sets err bit 0 only, and `rdata` carries the received byte, which is 8'hFF when nobody drives SDA.
- R5: The master answers the received byte with a NACK: SDA stays released (high) through the ninth SCL pulse of that byte.
- R6: Outside START and STOP, SDA changes only while SCL is low. SDA falls with SCL high only in START, and rises with SCL high only in STOP.
- R7: One tick occurs every prescale+1 clocks. A data-bit SCL high phase lasts T_HIGH ticks. In STOP, SDA rises 2*T_HIGH ticks after SCL rises.
- R8: `start` is ignored while `busy` is high, and each accepted request yields exactly one single-cycle `done`, in the cycle where `busy` has fallen.
- R9: After reset, busy and done are low and both SCL and SDA are released (scl_oe = sda_oe = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prescale | input | PRE_W | Tick spacing minus one, in clocks |
| start | input | 1 | Request pulse, taken only when idle |
| rw | input | 1 | 1 = register read, 0 = register write |
| dev_addr | input | 7 | Target device address |
| reg_idx | input | 8 | Register index |
| wdata | input | 8 | Value to write |
| sda_in | input | 1 | Sampled SDA line level |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| err | output | 3 | Error code of the last transaction |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
On every cycle, the assertions check the following:
- SDA edges with SCL high belong only to START or STOP.
- `done` lasts a single cycle, and request fields stay frozen while busy.
- A read never reports error bits above bit 0.
- The engine only takes an operation when it is idle.
- The tick never repeats on consecutive clocks for a nonzero prescale.
- Retries end once the budget is spent.

Only the bench scenarios, which use a modelled slave with pull-ups and selectable NACK injection, can show the rest:
- the order of the bytes and their content;
- which mask bits a refused slot sets;
- the number of START conditions each request produces;
- the NACK level on the ninth read pulse;
- measured phase durations.

// File: rtl/i2cm_pkg.sv
// Shared types for the I2C register master: the bus operations the
// transaction sequencer asks of the bus engine, and the error width.
package i2cm_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BYTE  = 2'd1,
        OP_STOP  = 2'd2,
        OP_GAP   = 2'd3
    } bus_op_e;

    localparam int ERR_W = 3;
endpackage

// File: rtl/i2cm_tick_gen.sv
// Clock-enable generator: asserts tick once every prescale+1 clocks.
// Assumes prescale is held steady while a transaction runs.
module i2cm_tick_gen #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;

    assign tick = (cnt >= prescale);

    // Count clocks between ticks, wrapping when the limit is met.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && prescale != '0 && $stable(prescale)) |=> (!tick || prescale == '0)); // R7
endmodule

// File: rtl/i2cm_bus_engine.sv
// Bus engine: executes one bus operation (START, 9-bit byte slot, STOP or
// low gap) as a sequence of timed phases counted in ticks. Line levels are
// registered and held between operations so the bus never glitches idle.
// A byte slot shifts out tx9 MSB first and samples SDA at the end of each
// SCL high phase into rx9; bit 0 of tx9/rx9 is the acknowledge slot.
// Assumes op_valid is only raised while the engine is idle.
module i2cm_bus_engine
    import i2cm_pkg::*;
#(
    parameter int T_LOW  = 8,
    parameter int T_HIGH = 8,
    parameter int T_HOLD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       op_valid,
    input  bus_op_e    op,
    input  logic [8:0] tx9,
    input  logic       sda_in,
    output logic       op_done,
    output logic [8:0] rx9,
    output logic       scl_lvl,
    output logic       sda_lvl
);
    localparam int LONG_A = (2 * T_LOW > 2 * T_HIGH) ? 2 * T_LOW : 2 * T_HIGH;
    localparam int MAXLEN = (LONG_A > T_HOLD) ? LONG_A : T_HOLD;
    localparam int CNT_W  = $clog2(MAXLEN + 1);
    localparam int HALF_L = (T_LOW / 2 > 0) ? T_LOW / 2 : 1;

    logic             active;
    bus_op_e          cur_op;
    logic [1:0]       ph;
    logic [3:0]       bitn;
    logic [CNT_W-1:0] cnt;
    logic [8:0]       txs;
    logic [8:0]       rxs;
    logic             scl_q, sda_q;
    logic [1:0]       sda_sync;
    logic             spec_scl, spec_sda, spec_last;
    logic [CNT_W-1:0] spec_len;

    assign rx9     = rxs;
    assign scl_lvl = scl_q;
    assign sda_lvl = sda_q;

    // Line levels, length and last-phase flag of the current phase.
    always_comb begin
        spec_scl  = 1'b0;
        spec_sda  = 1'b1;
        spec_len  = CNT_W'(T_LOW);
        spec_last = 1'b0;
        unique case (cur_op)
            OP_START: unique case (ph)
                2'd0: begin spec_scl = 1'b0; spec_sda = 1'b1; spec_len = CNT_W'(HALF_L); end
                2'd1: begin spec_scl = 1'b1; spec_sda = 1'b1; spec_len = CNT_W'(T_HIGH); end
                2'd2: begin spec_scl = 1'b1; spec_sda = 1'b0; spec_len = CNT_W'(T_HOLD); end
                default: begin spec_scl = 1'b0; spec_sda = 1'b0; spec_len = CNT_W'(T_LOW); spec_last = 1'b1; end
            endcase
            OP_BYTE: begin
                spec_sda = txs[8];
                unique case (ph)
                    2'd0:    begin spec_scl = 1'b0; spec_len = CNT_W'(HALF_L); end
                    2'd1:    begin spec_scl = 1'b1; spec_len = CNT_W'(T_HIGH); end
                    default: begin spec_scl = 1'b0; spec_len = CNT_W'(HALF_L); spec_last = (bitn == 4'd8); end
                endcase
            end
            OP_STOP: unique case (ph)
                2'd0:    begin spec_scl = 1'b0; spec_sda = 1'b0; spec_len = CNT_W'(2 * T_LOW); end
                2'd1:    begin spec_scl = 1'b1; spec_sda = 1'b0; spec_len = CNT_W'(2 * T_HIGH); end
                default: begin spec_scl = 1'b1; spec_sda = 1'b1; spec_len = CNT_W'(T_HOLD); spec_last = 1'b1; end
            endcase
            default: begin spec_scl = 1'b0; spec_sda = 1'b1; spec_len = CNT_W'(T_LOW); spec_last = 1'b1; end
        endcase
    end

    // Two-flop synchronizer for the incoming SDA level.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_sync <= 2'b11;
        else        sda_sync <= {sda_sync[0], sda_in};
    end

    // Phase sequencing, bit shifting, sampling and line level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cur_op  <= OP_GAP;
            ph      <= '0;
            bitn    <= '0;
            cnt     <= '0;
            txs     <= '1;
            rxs     <= '1;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            op_done <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (!active) begin
                if (op_valid) begin
                    active <= 1'b1;
                    cur_op <= op;
                    ph     <= '0;
                    bitn   <= '0;
                    cnt    <= '0;
                    txs    <= tx9;
                end
            end else begin
                scl_q <= spec_scl;
                sda_q <= spec_sda;
                if (tick) begin
                    if (cnt == spec_len - 1'b1) begin
                        cnt <= '0;
                        if (cur_op == OP_BYTE && ph == 2'd1)
                            rxs <= {rxs[7:0], sda_sync[1]};
                        if (spec_last) begin
                            active  <= 1'b0;
                            op_done <= 1'b1;
                        end else if (cur_op == OP_BYTE && ph == 2'd2) begin
                            ph   <= '0;
                            bitn <= bitn + 1'b1;
                            txs  <= {txs[7:0], 1'b1};
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_SDA_FALL_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) && $fell(sda_q)) |-> (cur_op == OP_START)); // R6
    AST_SDA_RISE_ONLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) && $rose(sda_q)) |-> (cur_op == OP_STOP)); // R6
    AST_OP_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> !active); // R1
    AST_BIT_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cur_op == OP_BYTE) |-> (bitn <= 4'd8)); // R1
endmodule

// File: rtl/i2cm_txn_seq.sv
// Transaction sequencer: latches a request, walks the step list of a
// register write or read, issues one bus operation per step, gathers the
// acknowledge results into an error code and repeats the whole transaction
// from START while errors remain and retries are left.
// Assumes the engine raises op_done exactly once per issued operation.
module i2cm_txn_seq
    import i2cm_pkg::*;
#(
    parameter int RETRIES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rw,
    input  logic [6:0]       dev_addr,
    input  logic [7:0]       reg_idx,
    input  logic [7:0]       wdata,
    input  logic             op_done,
    input  logic [8:0]       rx9,
    output logic             op_valid,
    output bus_op_e          op,
    output logic [8:0]       tx9,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rdata,
    output logic [ERR_W-1:0] err
);
    localparam int TRY_W = (RETRIES > 0) ? $clog2(RETRIES + 1) : 1;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_state_e;

    seq_state_e       state;
    logic             l_rw;
    logic [6:0]       l_addr;
    logic [7:0]       l_reg, l_wdata, rbuf;
    logic [2:0]       step;
    logic [TRY_W-1:0] tries;
    logic [ERR_W-1:0] err_acc, ack_mask, err_nxt;
    logic             is_last;

    assign busy     = (state != S_IDLE);
    assign op_valid = (state == S_ISSUE);
    assign err_nxt  = err_acc | (rx9[0] ? ack_mask : '0);

    // Decode the current step into a bus operation and its error bit.
    always_comb begin
        op       = OP_STOP;
        tx9      = 9'h1FF;
        ack_mask = '0;
        is_last  = 1'b0;
        if (!l_rw) begin
            unique case (step)
                3'd0: op = OP_START;
                3'd1: begin op = OP_BYTE; tx9 = {l_addr, 1'b0, 1'b1}; ack_mask = 3'b001; end
                3'd2: begin op = OP_BYTE; tx9 = {l_reg, 1'b1};        ack_mask = 3'b010; end
                3'd3: begin op = OP_BYTE; tx9 = {l_wdata, 1'b1};      ack_mask = 3'b100; end
                default: begin op = OP_STOP; is_last = 1'b1; end
            endcase
        end else begin
            unique case (step)
                3'd0: op = OP_START;
                3'd1: begin op = OP_BYTE; tx9 = {l_addr, 1'b0, 1'b1}; ack_mask = 3'b001; end
                3'd2: begin op = OP_BYTE; tx9 = {l_reg, 1'b1};        ack_mask = 3'b001; end
                3'd3: op = OP_GAP;
                3'd4: op = OP_START;
                3'd5: begin op = OP_BYTE; tx9 = {l_addr, 1'b1, 1'b1}; ack_mask = 3'b001; end
                3'd6: begin op = OP_BYTE; tx9 = 9'h1FF; end
                default: begin op = OP_STOP; is_last = 1'b1; end
            endcase
        end
    end

    // Request capture, step walking, error gathering and retry control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            l_rw    <= 1'b0;
            l_addr  <= '0;
            l_reg   <= '0;
            l_wdata <= '0;
            rbuf    <= '1;
            step    <= '0;
            tries   <= '0;
            err_acc <= '0;
            done    <= 1'b0;
            rdata   <= '0;
            err     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    l_rw    <= rw;
                    l_addr  <= dev_addr;
                    l_reg   <= reg_idx;
                    l_wdata <= wdata;
                    step    <= '0;
                    tries   <= TRY_W'(RETRIES);
                    err_acc <= '0;
                    state   <= S_ISSUE;
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: if (op_done) begin
                    if (l_rw && step == 3'd6) rbuf <= rx9[8:1];
                    if (is_last) begin
                        if (err_acc != '0 && tries != '0) begin
                            tries   <= tries - 1'b1;
                            step    <= '0;
                            err_acc <= '0;
                            state   <= S_ISSUE;
                        end else begin
                            done  <= 1'b1;
                            err   <= err_acc;
                            if (l_rw) rdata <= rbuf;
                            state <= S_IDLE;
                        end
                    end else begin
                        err_acc <= err_nxt;
                        step    <= step + 1'b1;
                        state   <= S_ISSUE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_REQUEST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(l_addr) && $stable(l_wdata) && $stable(l_reg))); // R8
    AST_READ_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && l_rw) |-> (err[2:1] == 2'b00)); // R4
    AST_RETRY_BUDGET_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && op_done && is_last && tries == '0) |=> (state == S_IDLE)); // R3
endmodule

// File: rtl/i2c_regm.sv
// Top of the I2C register master: prescaler, transaction sequencer and
// bus engine. The bus pins are open drain: an output enable of 1 pulls the
// line low, 0 releases it to the external pull-up.
// Assumes a single master, no clock stretching and a steady prescale.
module i2c_regm
    import i2cm_pkg::*;
#(
    parameter int PRE_W   = 8,
    parameter int T_LOW   = 8,
    parameter int T_HIGH  = 8,
    parameter int T_HOLD  = 8,
    parameter int RETRIES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PRE_W-1:0] prescale,
    input  logic             start,
    input  logic             rw,
    input  logic [6:0]       dev_addr,
    input  logic [7:0]       reg_idx,
    input  logic [7:0]       wdata,
    input  logic             sda_in,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rdata,
    output logic [2:0]       err,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic       tick, op_valid, op_done, scl_lvl, sda_lvl;
    logic [8:0] tx9, rx9;
    bus_op_e    op;

    assign scl_oe = ~scl_lvl;
    assign sda_oe = ~sda_lvl;

    i2cm_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .tick(tick)
    );

    i2cm_txn_seq #(.RETRIES(RETRIES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rw(rw),
        .dev_addr(dev_addr), .reg_idx(reg_idx), .wdata(wdata),
        .op_done(op_done), .rx9(rx9), .op_valid(op_valid), .op(op),
        .tx9(tx9), .busy(busy), .done(done), .rdata(rdata), .err(err)
    );

    i2cm_bus_engine #(.T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_HOLD(T_HOLD)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .op_valid(op_valid),
        .op(op), .tx9(tx9), .sda_in(sda_in), .op_done(op_done),
        .rx9(rx9), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
    );

    AST_RESET_RELEASED: assert property (@(posedge clk)
        $past(!rst_n) |-> (!scl_oe && !sda_oe && !busy)); // R9
endmodule

// File: tb/i2c_regm_bench.sv
module i2c_regm_bench;
    localparam logic [6:0] SLV = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] prescale = 8'd1;
    logic       start = 1'b0, rw = 1'b0;
    logic [6:0] dev_addr = '0;
    logic [7:0] reg_idx = '0, wdata = '0;
    logic       busy, done, scl_oe, sda_oe;
    logic [7:0] rdata;
    logic [2:0] err;
    logic       slv_pull;
    wire        scl_bus = ~scl_oe;
    wire        sda_bus = ~(sda_oe | slv_pull);

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    i2c_regm u_i2c_regm (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .start(start), .rw(rw),
        .dev_addr(dev_addr), .reg_idx(reg_idx), .wdata(wdata), .sda_in(sda_bus),
        .busy(busy), .done(done), .rdata(rdata), .err(err),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // ---------------- slave model with register file and NACK injection
    logic [7:0] mem [256];
    int   start_cnt = 0, nack_used = 0, nack_limit = 0, nack_phase = 0;
    int   bitc = 0, byte_idx = 0, ph = 0;
    logic prev_scl = 1'b1, prev_sda = 1'b1, rd_mode = 1'b0, sel = 1'b0;
    logic rw_bit = 1'b0, ack = 1'b0, ack_given = 1'b0, mst_ack_bit = 1'b0;
    logic [7:0] shin = '0, reg_ptr = '0, txb = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
            slv_pull <= 1'b0;
            bitc = 0; rd_mode = 1'b0; sel = 1'b0;
            prev_scl = 1'b1; prev_sda = 1'b1;
        end else begin
            if (scl_bus && prev_scl && prev_sda && !sda_bus) begin
                start_cnt++; bitc = 0; byte_idx = 0; rd_mode = 1'b0; sel = 1'b0;
                slv_pull <= 1'b0;
            end else if (scl_bus && prev_scl && !prev_sda && sda_bus) begin
                bitc = 0; rd_mode = 1'b0; sel = 1'b0; slv_pull <= 1'b0;
            end else if (scl_bus && !prev_scl) begin
                if (bitc < 8) shin = {shin[6:0], sda_bus};
                if (rd_mode && bitc == 8) mst_ack_bit = sda_bus;
                bitc++;
            end else if (!scl_bus && prev_scl) begin
                if (bitc == 8 && !rd_mode) begin
                    ack = 1'b0;
                    case (byte_idx)
                        0: begin
                            rw_bit = shin[0];
                            sel = (shin[7:1] == SLV);
                            ph = rw_bit ? 4 : 1;
                            ack = sel;
                        end
                        1: begin ph = 2; ack = sel; if (sel) reg_ptr = shin; end
                        2: begin ph = 3; ack = sel; end
                        default: begin ph = 0; ack = 1'b0; end
                    endcase
                    if (ack && nack_phase == ph && nack_used < nack_limit) begin
                        nack_used++;
                        ack = 1'b0;
                        if (ph == 1 || ph == 4) sel = 1'b0;
                    end
                    if (ack && byte_idx == 2) mem[reg_ptr] = shin;
                    ack_given = ack;
                    slv_pull <= ack;
                end else if (bitc == 8) begin
                    slv_pull <= 1'b0;
                end else if (bitc == 9) begin
                    bitc = 0;
                    slv_pull <= 1'b0;
                    if (!rd_mode && byte_idx == 0 && ack_given && rw_bit) begin
                        rd_mode = 1'b1;
                        txb = mem[reg_ptr];
                        slv_pull <= ~txb[7];
                    end
                    byte_idx++;
                end else if (rd_mode && bitc >= 1) begin
                    slv_pull <= ~txb[7 - bitc];
                end
            end
            prev_scl = scl_bus;
            prev_sda = sda_bus;
        end
    end

    // ---------------- phase duration monitor (in clocks)
    int cyc = 0, hi_t = 0, last_hi = 0, stop_w = 0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    always @(posedge clk) begin
        cyc++;
        if (scl_bus && !m_scl) hi_t = cyc;
        if (!scl_bus && m_scl) last_hi = cyc - hi_t;
        if (scl_bus && m_scl && sda_bus && !m_sda) stop_w = cyc - hi_t;
        m_scl = scl_bus;
        m_sda = sda_bus;
    end

    // ---------------- checking helpers
    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic r, input logic [6:0] a, input logic [7:0] ri,
                           input logic [7:0] wd);
        int waited;
        @(negedge clk);
        rw = r; dev_addr = a; reg_idx = ri; wdata = wd; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 40000) begin
            @(negedge clk);
            waited++;
        end
        if (!done) begin
            fails++;
            $display("FAIL R8 actual=timeout expected=done");
        end
    endtask

    typedef struct packed {
        logic       rw;
        logic [6:0] addr;
        logic [7:0] regi;
        logic [7:0] wdata;
        logic [2:0] nph;
        logic [2:0] nleft;
        logic [2:0] eerr;
        logic [3:0] estarts;
        logic [7:0] erd;
        logic       chkrd;
    } vec_t;

    // phase codes: 1 address (write bit), 2 register index, 3 data, 4 address (read bit)
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'h2A, 8'h10, 8'hC3, 3'd0, 3'd0, 3'b000, 4'd1, 8'h00, 1'b0}, // R1
        '{1'b1, 7'h2A, 8'h10, 8'h00, 3'd0, 3'd0, 3'b000, 4'd2, 8'hC3, 1'b1}, // R4
        '{1'b0, 7'h2A, 8'h11, 8'h3C, 3'd2, 3'd1, 3'b000, 4'd2, 8'h00, 1'b0}, // R3
        '{1'b1, 7'h2A, 8'h11, 8'h00, 3'd0, 3'd0, 3'b000, 4'd2, 8'h3C, 1'b1}, // R1
        '{1'b0, 7'h2A, 8'h12, 8'h81, 3'd3, 3'd4, 3'b100, 4'd4, 8'h00, 1'b0}, // R2
        '{1'b0, 7'h2A, 8'h13, 8'h44, 3'd1, 3'd4, 3'b111, 4'd4, 8'h00, 1'b0}, // R2
        '{1'b0, 7'h2A, 8'h13, 8'h44, 3'd2, 3'd7, 3'b010, 4'd4, 8'h00, 1'b0}, // R2
        '{1'b1, 7'h2A, 8'h13, 8'h00, 3'd4, 3'd4, 3'b001, 4'd8, 8'hFF, 1'b1}, // R4
        '{1'b1, 7'h2A, 8'h13, 8'h00, 3'd2, 3'd1, 3'b000, 4'd4, 8'h44, 1'b1}, // R3
        '{1'b1, 7'h2A, 8'h05, 8'h00, 3'd0, 3'd0, 3'b000, 4'd2, 8'h5F, 1'b1}, // R4
        '{1'b0, 7'h11, 8'h20, 8'h99, 3'd0, 3'd0, 3'b111, 4'd4, 8'h00, 1'b0}, // R2
        '{1'b1, 7'h2A, 8'h12, 8'h00, 3'd0, 3'd0, 3'b000, 4'd2, 8'h48, 1'b1}, // R2
        '{1'b1, 7'h2A, 8'h10, 8'h00, 3'd1, 3'd2, 3'b000, 4'd6, 8'hC3, 1'b1}, // R3
        '{1'b0, 7'h2A, 8'h14, 8'h77, 3'd1, 3'd5, 3'b111, 4'd4, 8'h00, 1'b0}, // R3
        '{1'b1, 7'h2A, 8'h14, 8'h00, 3'd0, 3'd0, 3'b000, 4'd2, 8'h4E, 1'b1}  // R3
    };

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int s0;
        repeat (4) @(negedge clk);
        // R9: reset state
        check("R9 busy", int'(busy), 0);
        check("R9 done", int'(done), 0);
        check("R9 lines released", int'({scl_oe, sda_oe}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            nack_phase = int'(VECS[v].nph);
            nack_limit = nack_used + int'(VECS[v].nleft);
            mst_ack_bit = 1'b0;
            s0 = start_cnt;
            run_txn(VECS[v].rw, VECS[v].addr, VECS[v].regi, VECS[v].wdata);
            check(VECS[v].rw ? "R4 err" : "R2 err", int'(err), int'(VECS[v].eerr));
            check("R3 attempts (START count)", start_cnt - s0, int'(VECS[v].estarts));
            check("R8 busy low at done", int'(busy), 0);
            if (VECS[v].chkrd) check("R4 rdata", int'(rdata), int'(VECS[v].erd));
            if (VECS[v].chkrd && VECS[v].eerr == 3'b000)
                check("R5 NACK on ninth pulse", int'(mst_ack_bit), 1);
            @(negedge clk);
            check("R8 done single cycle", int'(done), 0);
        end

        // R8: a start pulse while busy is ignored
        nack_phase = 0;
        s0 = start_cnt;
        @(negedge clk);
        rw = 1'b0; dev_addr = SLV; reg_idx = 8'h20; wdata = 8'h11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        reg_idx = 8'h21; wdata = 8'h22; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (3000) @(negedge clk);
        check("R8 no second transaction", start_cnt - s0, 1);
        check("R8 idle after", int'(busy), 0);
        run_txn(1'b1, SLV, 8'h21, 8'h00);
        check("R8 ignored request left reg untouched", int'(rdata), 8'h21 ^ 8'h5A);
        run_txn(1'b1, SLV, 8'h20, 8'h00);
        check("R1 accepted request written", int'(rdata), 8'h11);

        // R7: phase durations at prescale 3 (tick every 4 clocks)
        prescale = 8'd3;
        repeat (8) @(negedge clk);
        run_txn(1'b0, SLV, 8'h30, 8'hA5);
        check("R7 SCL high of a bit", last_hi, 8 * 4);
        check("R7 STOP high before SDA rise", stop_w, 16 * 4);
        run_txn(1'b1, SLV, 8'h30, 8'h00);
        check("R1 MSB-first readback", int'(rdata), 8'hA5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule